// File: doc/BRIEF.md
# Burst Offset Sequencer

This block generates the low address bits that walk a four-beat burst in a synchronous memory. A begin-burst cycle loads an external starting offset. Each following continue-burst cycle moves to the next beat. The beat order is either a plain wrap-around count or an XOR pattern, and an order-select input picks between them when the burst is loaded. An active-high stall input freezes the block completely for as long as it is held.

Inside, a two-state controller tracks whether a burst has been opened since reset:

- `ST_IDLE` is entered on reset. An advance request here has no effect.
- `ST_BURST` is entered from `ST_IDLE` by a load that is not stalled. Once in `ST_BURST` the block stays there until the next reset, and later loads restart the burst in place.

The tracker registers the starting offset, the order and a beat count that begins at zero at each load. The offset is formed from these registers, so a load or a step seen at one rising edge shows on the output just after that edge.

Top module: `bseq_top`

## Requirements
- R1: With the order latched as 1 (interleaved), the offset after k steps since the load equals start XOR k, for k = 0, 1, 2, 3.
- R2: With the order latched as 0 (linear), the offset after k steps equals (start + k) modulo 4.
- R3: After the fourth step since the load, the offset is back at the loaded start value, in both orders.
- R4: A load sampled with stall low makes the offset equal to start_ofs after that edge and restarts the beat count at zero. A load takes priority over an advance in the same cycle.
- R5: While stall is high at an edge, the offset and all internal state keep their values, and any load or advance in that cycle is ignored.
- R6: In a cycle with stall low and with load and advance both low, the offset keeps its value.
- R7: A synchronous reset (rst high at an edge) clears the offset to 0 and returns the controller to `ST_IDLE`.
- R8: order_sel is sampled only at a load. Changes to it during a burst do not alter the order in use.
- R9: In `ST_IDLE`, that is before any load since reset, an advance leaves the offset at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | High freezes the block for that cycle |
| load | input | 1 | Begin-burst: capture start_ofs and order_sel |
| advance | input | 1 | Continue-burst: step to the next beat |
| order_sel | input | 1 | 1 = interleaved, 0 = linear; sampled at load |
| start_ofs | input | OFS_W | Starting offset of the burst |
| ofs | output | OFS_W | Current burst offset |

## Verification
On every cycle the bound checker enforces several rules:

- reset to zero;
- the freeze under stall;
- load capture and its priority over advance;
- both step rules, checked against the registered start and beat count;
- the return to the start on the fourth step;
- the idle refusal to step.

Some behaviour can only be shown by the bench's scenarios, because it spans many cycles and depends on inputs that change between the load and later cycles. This covers whole four-beat sequences from odd and even starts, and an order pin that toggles during a burst. It also covers a stalled load that must not replace a burst in progress, and a reset in the middle of a burst followed by a stray advance.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } state_e;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stall,
    input  logic   load,
    input  logic   advance,
    output state_e state_o,
    output logic   ld_en,
    output logic   step_en
);

    state_e state_q;
    state_e state_d;
    logic   go;

    assign go = ~stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go && load) begin
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                state_d = ST_BURST;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ld_en   = 1'b0;
        step_en = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ld_en = go & load;
            end
            ST_BURST: begin
                ld_en   = go & load;
                step_en = go & ~load & advance;
            end
            default: begin
                ld_en   = 1'b0;
                step_en = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/bseq_track.sv
module bseq_track
    import bseq_pkg::*;
#(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic         step_en,
    input  logic [W-1:0] start_i,
    input  logic         order_i,
    output logic [W-1:0] start_q,
    output logic [W-1:0] beat_q,
    output order_e       order_q
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= '0;
            order_q <= ORD_LINEAR;
        end else if (ld_en) begin
            start_q <= start_i;
            beat_q  <= '0;
            order_q <= order_i ? ORD_XOR : ORD_LINEAR;
        end else if (step_en) begin
            beat_q  <= beat_q + ONE;
        end
    end

endmodule

// File: rtl/bseq_map.sv
module bseq_map
    import bseq_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] beat_i,
    input  order_e       order_i,
    output logic [W-1:0] ofs_o
);

    logic [W-1:0] lin_ofs;
    logic [W-1:0] xor_ofs;

    assign lin_ofs = start_i + beat_i;

    for (genvar b = 0; b < W; b++) begin : g_xor_bit
        assign xor_ofs[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (order_i)
            ORD_LINEAR: ofs_o = lin_ofs;
            ORD_XOR:    ofs_o = xor_ofs;
            default:    ofs_o = lin_ofs;
        endcase
    end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             load,
    input  logic             advance,
    input  logic             order_sel,
    input  logic [OFS_W-1:0] start_ofs,
    output logic [OFS_W-1:0] ofs
);

    state_e           st;
    logic             ld_en;
    logic             step_en;
    logic [OFS_W-1:0] start_q;
    logic [OFS_W-1:0] beat_q;
    order_e           order_q;

    bseq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .load    (load),
        .advance (advance),
        .state_o (st),
        .ld_en   (ld_en),
        .step_en (step_en)
    );

    bseq_track #(.W(OFS_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .step_en (step_en),
        .start_i (start_ofs),
        .order_i (order_sel),
        .start_q (start_q),
        .beat_q  (beat_q),
        .order_q (order_q)
    );

    bseq_map #(.W(OFS_W)) u_map (
        .start_i (start_q),
        .beat_i  (beat_q),
        .order_i (order_q),
        .ofs_o   (ofs)
    );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int W = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         stall,
    input logic         load,
    input logic         advance,
    input logic [W-1:0] start_ofs,
    input logic [W-1:0] ofs,
    input state_e       st,
    input logic [W-1:0] start_q,
    input logic [W-1:0] beat_q,
    input order_e       order_q
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] LAST = '1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ofs == '0 && st == ST_IDLE)); // R7

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(ofs) && $stable(beat_q) && $stable(start_q))); // R5

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!stall && load) |=> (ofs == $past(start_ofs) && beat_q == '0)); // R4

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && advance && st == ST_BURST && order_q == ORD_LINEAR)
        |=> (ofs == $past(ofs) + ONE)); // R2

    AST_XOR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && advance && st == ST_BURST && order_q == ORD_XOR)
        |=> (ofs == ($past(start_q) ^ ($past(beat_q) + ONE)))); // R1

    AST_WRAP_HOME: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && advance && st == ST_BURST && beat_q == LAST)
        |=> (ofs == start_q)); // R3

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!stall && !load && !advance) |=> $stable(ofs)); // R6

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !load) |=> (ofs == '0)); // R9

    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (stall || !load) |=> $stable(order_q)); // R8

endmodule

bind bseq_top bseq_chk #(.W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .load      (load),
    .advance   (advance),
    .start_ofs (start_ofs),
    .ofs       (ofs),
    .st        (st),
    .start_q   (start_q),
    .beat_q    (beat_q),
    .order_q   (order_q)
);

// File: tb/bseq_top_bench.sv
module bseq_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       stall;
    logic       load;
    logic       advance;
    logic       order_sel;
    logic [1:0] start_ofs;
    logic [1:0] ofs;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bseq_top #(.OFS_W(2)) u_bseq_top (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .load      (load),
        .advance   (advance),
        .order_sel (order_sel),
        .start_ofs (start_ofs),
        .ofs       (ofs)
    );

    // {stall, load, advance, order_sel, start[1:0], expected ofs[1:0]}
    localparam int NV = 22;
    localparam logic [7:0] VEC [NV] = '{
        8'b0100_0101, // R4 load linear start 1
        8'b0010_0010, // R2 step -> 2
        8'b0010_0011, // R2 step -> 3
        8'b0010_0000, // R2 step -> 0
        8'b0010_0001, // R3 fourth step back to 1
        8'b0101_0101, // R4 load interleaved start 1
        8'b0010_0000, // R1 1^1
        8'b0010_0011, // R1 1^2
        8'b0010_0010, // R1 1^3
        8'b0010_0001, // R3 back to 1
        8'b1010_0001, // R5 stalled advance ignored
        8'b1100_1001, // R5 stalled load ignored
        8'b0010_0000, // R8 pin low, interleaved kept: 1^1
        8'b0010_0011, // R8 1^2
        8'b0110_1111, // R4 load linear 3 beats advance
        8'b0010_0000, // R2 3+1
        8'b0010_0001, // R2 3+2
        8'b0000_0001, // R6 quiet cycle holds
        8'b0101_1111, // R4 load interleaved start 3
        8'b0010_0010, // R1 3^1
        8'b0010_0001, // R1 3^2
        8'b0010_0000  // R1 3^3
    };

    function automatic string tag_of(input logic [7:0] v);
        if (v[7])      return "R5";
        else if (v[6]) return "R4";
        else if (v[5]) return "R1/R2/R3/R8";
        else           return "R6";
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        n_run++;
        if (ofs !== exp) begin
            n_fail++;
            $display("FAIL %s: ofs=%0d expected=%0d at %0t", req, ofs, exp, $time);
        end
    endtask

    task automatic drive(input logic s, input logic l, input logic a,
                         input logic m, input logic [1:0] st);
        @(negedge clk);
        stall = s; load = l; advance = a; order_sel = m; start_ofs = st;
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; stall = 1'b0; load = 1'b0; advance = 1'b0;
        order_sel = 1'b0; start_ofs = 2'd0;
        repeat (2) @(posedge clk);
        #2;
        check("R7 reset value", 2'd0);
        @(negedge clk);
        rst = 1'b0;

        // R9: advance before any load stays at 0
        drive(1'b0, 1'b0, 1'b1, 1'b1, 2'd3);
        check("R9 idle advance", 2'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd2);
        check("R9 idle advance again", 2'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:2]);
            check($sformatf("%s vector %0d", tag_of(VEC[i]), i), VEC[i][1:0]);
        end

        // R7: reset mid-burst, then R9 stray advance
        drive(1'b0, 1'b1, 1'b0, 1'b1, 2'd2);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
        check("R1 2^1", 2'd3);
        @(negedge clk);
        rst = 1'b1; advance = 1'b0;
        @(posedge clk);
        #2;
        check("R7 mid-burst reset", 2'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
        check("R9 advance after reset", 2'd0);

        // R4 load then R3 full linear lap from 2
        drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd2);
        check("R4 load 2", 2'd2);
        for (int k = 1; k <= 4; k++) begin
            drive(1'b0, 1'b0, 1'b1, 1'b1, 2'd0);
            check("R2/R3 linear lap", 2'((2 + k) % 4));
        end

        finish_run();
    end

endmodule